// File: doc/BRIEF.md
# Indexed Block Register Target for a Two-Wire Management Bus

This block is a two-wire bus target that owns a small bank of 8-bit configuration registers for a clock-distribution device. It watches SCL and SDA through a synchroniser clocked by a much faster system clock and drives SDA through an open-drain pull-down enable. A write transfer carries a starting index and a byte count ahead of its data. A read transfer first sets the index with a short write, then follows a repeated START with the read address. The target then returns the byte count held in its count register, followed by consecutive registers.

The register contents are presented as parallel outputs to the neighbouring clock-control logic. Index 0 is a mixed control register: three bits are host-writable, two bits read back mode-pin levels captured just after reset, and the remaining bits are constants. Index 1 holds per-output enables. Index 2 holds per-output stop selects. The last index holds the read byte count. Every index in between is reserved.

Top module: `smb_idx_target`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal 0x6E (0xDC to write, 0xDD to read). On any other address it acknowledges nothing and keeps SDA released until the next START or STOP.
- R2: After a write address, the first byte is taken as the starting index N and the second as the byte count X; all three bytes are acknowledged. The following data bytes are written to indices N, N+1, and so on, with an acknowledge after each one.
- R3: A data byte that arrives after X data bytes have already been accepted is not acknowledged and is not stored.
- R4: A repeated START followed by the read address makes the target send the content of the count register (index 8) first. It then sends registers N, N+1, and so on, most significant bit first, where N is the last index written.
- R5: When the host does not acknowledge a byte the target sends, the target releases SDA and sends nothing more until the next START.
- R6: After reset, index 1 is 0xFF, index 2 is 0x00, the count register is 9, and index 0 reads with bit 7 = 1, bit 6 = 0 and bit 0 = 1.
- R7: In index 0, only bits 7, 6 and 0 are writable. Bit 3 reads mode pin 1 and bit 1 reads mode pin 0, both captured once in the first clock after reset. Bit 2 reads 1, and bits 5 and 4 read 0.
- R8: Indices 3 to 7, and indices at or above 9, read as 0x00. Data written to them is acknowledged but ignored.
- R9: A STOP or a repeated START in the middle of a transfer ends it at once. Register bytes already fully received are kept, and a partial byte is discarded.
- R10: The outputs cfg0_o, out_en_o, stop_sel_o and rd_count_o always show the readback of indices 0, 1, 2 and 8.
- R11: The target changes its SDA pull-down only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |
| mode_pins_i | input | 2 | Mode pin levels, captured after reset |
| cfg0_o | output | 8 | Readback of index 0 |
| out_en_o | output | 8 | Per-output enables, index 1 |
| stop_sel_o | output | 8 | Per-output stop selects, index 2 |
| rd_count_o | output | 8 | Read byte count, index 8 |

## Verification
The hardest case to reach from the pins is a transfer cut short: a STOP in the middle of a data byte, or a repeated START straight after an acknowledged data byte. In either case the bus must leave behind exactly the bytes that were complete. The stimulus gets there with a host model that can abandon a byte after any bit and then issue a STOP, or issue a repeated START followed by a read. In the read, the count and the register at the advanced index both show where the write pointer stopped. A behavioural register model is compared on every clock, so a byte that is written one byte too early, too late or twice shows up at once.

// File: rtl/smb_idx_pkg.sv
package smb_idx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_RACK
   } bus_state_t;

   typedef enum logic [1:0] {
      PH_ADDR,
      PH_INDEX,
      PH_COUNT,
      PH_DATA
   } phase_t;

   localparam logic [7:0] CTRL_WMASK = 8'hC1;
   localparam logic [7:0] CTRL_RST   = 8'h81;

   function automatic logic [7:0] reg_wmask(input int idx, input int cnt_idx);
      if (idx == 0)                     return CTRL_WMASK;
      if (idx == 1 || idx == 2)         return 8'hFF;
      if (idx == cnt_idx)               return 8'hFF;
      return 8'h00;
   endfunction

   function automatic logic [7:0] reg_rstval(input int idx, input int cnt_idx,
                                             input logic [7:0] cnt_rst);
      if (idx == 0)       return CTRL_RST;
      if (idx == 1)       return 8'hFF;
      if (idx == cnt_idx) return cnt_rst;
      return 8'h00;
   endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("smb_line_sync: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
   logic                   scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_d    <= 1'b1;
         sda_d    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
         scl_d    <= scl_pipe[SYNC_STAGES-1];
         sda_d    <= sda_pipe[SYNC_STAGES-1];
      end
   end

   assign scl_s     = scl_pipe[SYNC_STAGES-1];
   assign sda_s     = sda_pipe[SYNC_STAGES-1];
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank
   import smb_idx_pkg::*;
#(
   parameter int         NUM_REGS = 9,
   parameter logic [7:0] CNT_RST  = 8'd9
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_idx,
   input  logic [7:0] wr_data,
   input  logic [7:0] rd_idx,
   output logic [7:0] rd_data,
   input  logic [1:0] mode_pins_i,
   output logic       mode_cap,
   output logic [7:0] cfg0_o,
   output logic [7:0] out_en_o,
   output logic [7:0] stop_sel_o,
   output logic [7:0] rd_count_o
);
   localparam int CNT_IDX = NUM_REGS - 1;

   if (NUM_REGS < 9 || NUM_REGS > 256) begin : g_bad_depth
      $error("smb_regbank: NUM_REGS must lie in 9..256");
   end

   logic [7:0] q   [NUM_REGS];
   logic [7:0] rbk [NUM_REGS];
   logic [1:0] mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= 2'b00;
         mode_cap <= 1'b0;
      end else if (!mode_cap) begin
         mode_q   <= mode_pins_i;
         mode_cap <= 1'b1;
      end
   end

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      localparam logic [7:0] WM = reg_wmask(i, CNT_IDX);
      localparam logic [7:0] RV = reg_rstval(i, CNT_IDX, CNT_RST);
      if (WM == 8'h00) begin : g_const
         assign q[i] = 8'h00;
      end else begin : g_store
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q[i] <= RV & WM;
            else if (wr_en && wr_idx == 8'(i))
               q[i] <= (q[i] & ~WM) | (wr_data & WM);
         end
      end
      if (i == 0) begin : g_ctrl_rbk
         assign rbk[i] = (q[i] & CTRL_WMASK) | {4'b0000, mode_q[1], 1'b1, mode_q[0], 1'b0};
      end else begin : g_plain_rbk
         assign rbk[i] = q[i];
      end
   end

   always_comb begin
      rd_data = 8'h00;
      for (int k = 0; k < NUM_REGS; k++)
         if (rd_idx == 8'(k)) rd_data = rbk[k];
   end

   assign cfg0_o     = rbk[0];
   assign out_en_o   = rbk[1];
   assign stop_sel_o = rbk[2];
   assign rd_count_o = rbk[CNT_IDX];
endmodule

// File: rtl/smb_idx_target.sv
module smb_idx_target
   import smb_idx_pkg::*;
#(
   parameter logic [6:0] TGT_ADDR    = 7'h6E,
   parameter int         NUM_REGS    = 9,
   parameter logic [7:0] CNT_RST     = 8'd9,
   parameter int         SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_pull_o,
   input  logic [1:0] mode_pins_i,
   output logic [7:0] cfg0_o,
   output logic [7:0] out_en_o,
   output logic [7:0] stop_sel_o,
   output logic [7:0] rd_count_o
);
   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

   smb_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   bus_state_t state;
   phase_t     phase;
   logic [3:0] bitcnt;
   logic [7:0] shreg, tx_sh, ptr, remain;
   logic       rd_mode, host_ack, sda_oe, mode_cap;
   logic [7:0] rd_data;
   logic       byte_done, accept, wr_en;

   assign byte_done = (state == ST_RX) && scl_fall && (bitcnt == 4'd8)
                      && !start_det && !stop_det;

   always_comb begin
      unique case (phase)
         PH_ADDR:  accept = (shreg[7:1] == TGT_ADDR);
         PH_DATA:  accept = (remain != 8'd0);
         default:  accept = 1'b1;
      endcase
   end

   assign wr_en = byte_done && (phase == PH_DATA) && (remain != 8'd0);

   smb_regbank #(.NUM_REGS(NUM_REGS), .CNT_RST(CNT_RST)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(ptr), .wr_data(shreg),
      .rd_idx(ptr), .rd_data(rd_data),
      .mode_pins_i(mode_pins_i), .mode_cap(mode_cap),
      .cfg0_o(cfg0_o), .out_en_o(out_en_o), .stop_sel_o(stop_sel_o),
      .rd_count_o(rd_count_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         phase    <= PH_ADDR;
         bitcnt   <= 4'd0;
         shreg    <= 8'h00;
         tx_sh    <= 8'h00;
         ptr      <= 8'h00;
         remain   <= 8'h00;
         rd_mode  <= 1'b0;
         host_ack <= 1'b0;
         sda_oe   <= 1'b0;
      end else if (start_det) begin
         state   <= ST_RX;
         phase   <= PH_ADDR;
         bitcnt  <= 4'd0;
         rd_mode <= 1'b0;
         sda_oe  <= 1'b0;
      end else if (stop_det) begin
         state  <= ST_IDLE;
         sda_oe <= 1'b0;
      end else begin
         unique case (state)
            ST_RX: begin
               if (scl_rise) begin
                  shreg  <= {shreg[6:0], sda_s};
                  bitcnt <= bitcnt + 4'd1;
               end else if (byte_done) begin
                  if (accept) begin
                     state  <= ST_ACK;
                     sda_oe <= 1'b1;
                     unique case (phase)
                        PH_ADDR: begin
                           rd_mode <= shreg[0];
                           tx_sh   <= rd_count_o;
                           phase   <= PH_INDEX;
                        end
                        PH_INDEX: begin
                           ptr   <= shreg;
                           phase <= PH_COUNT;
                        end
                        PH_COUNT: begin
                           remain <= shreg;
                           phase  <= PH_DATA;
                        end
                        default: begin
                           ptr    <= ptr + 8'd1;
                           remain <= remain - 8'd1;
                        end
                     endcase
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  bitcnt <= 4'd0;
                  if (rd_mode) begin
                     state  <= ST_TX;
                     sda_oe <= ~tx_sh[7];
                  end else begin
                     state  <= ST_RX;
                     sda_oe <= 1'b0;
                  end
               end
            end
            ST_TX: begin
               if (scl_rise) begin
                  bitcnt <= bitcnt + 4'd1;
               end else if (scl_fall) begin
                  if (bitcnt == 4'd8) begin
                     state  <= ST_RACK;
                     sda_oe <= 1'b0;
                  end else begin
                     tx_sh  <= {tx_sh[6:0], 1'b0};
                     sda_oe <= ~tx_sh[6];
                  end
               end
            end
            ST_RACK: begin
               if (scl_rise) begin
                  host_ack <= ~sda_s;
                  bitcnt   <= 4'd9;
               end else if (scl_fall && bitcnt == 4'd9) begin
                  if (host_ack) begin
                     state  <= ST_TX;
                     tx_sh  <= rd_data;
                     ptr    <= ptr + 8'd1;
                     sda_oe <= ~rd_data[7];
                     bitcnt <= 4'd0;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            default: sda_oe <= 1'b0;
         endcase
      end
   end

   assign sda_pull_o = sda_oe;
endmodule

// File: rtl/smb_idx_target_chk.sv
module smb_idx_target_chk #(
   parameter int NUM_REGS = 9
) (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_s,
   input logic       start_det,
   input logic       stop_det,
   input logic       sda_oe,
   input logic [7:0] rd_idx,
   input logic [7:0] rd_data,
   input logic       mode_cap,
   input logic [7:0] cfg0
);
   localparam int CNT_IDX = NUM_REGS - 1;

   p_pull_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s);

   p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);

   p_start_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !sda_oe);

   p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_idx >= 8'd3 && rd_idx < 8'(CNT_IDX)) || (int'(rd_idx) >= NUM_REGS))
      |-> rd_data == 8'h00);

   p_mode_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_cap && $past(mode_cap)) |-> ($stable(cfg0[3]) && $stable(cfg0[1])));

   p_fixed_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg0[2] && !cfg0[5] && !cfg0[4]);
endmodule

bind smb_idx_target smb_idx_target_chk #(.NUM_REGS(NUM_REGS)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
   .stop_det(stop_det), .sda_oe(sda_oe), .rd_idx(ptr), .rd_data(rd_data),
   .mode_cap(mode_cap), .cfg0(cfg0_o)
);

// File: tb/smb_idx_target_bench.sv
module smb_idx_target_bench;
   localparam int Q = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda_h = 1'b1;
   logic [1:0] mode_pins = 2'b10;
   logic       sda_pull_o;
   logic [7:0] cfg0_o, out_en_o, stop_sel_o, rd_count_o;
   wire        sda_line = sda_h & ~sda_pull_o;

   int checks = 0;
   int errors = 0;
   bit mon_en = 1'b0;
   bit watch_pull = 1'b0;
   bit saw_pull = 1'b0;
   bit done = 1'b0;

   logic [7:0] m [0:8];
   logic [1:0] mlat;

   always #5 clk = ~clk;

   smb_idx_target u_smb_idx_target (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
      .sda_pull_o(sda_pull_o), .mode_pins_i(mode_pins),
      .cfg0_o(cfg0_o), .out_en_o(out_en_o), .stop_sel_o(stop_sel_o),
      .rd_count_o(rd_count_o)
   );

   task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] m_read(input int idx);
      if (idx == 0) return (m[0] & 8'hC1) | {4'b0000, mlat[1], 1'b1, mlat[0], 1'b0};
      if (idx == 1 || idx == 2 || idx == 8) return m[idx];
      return 8'h00;
   endfunction

   function automatic void m_write(input int idx, input logic [7:0] v);
      if (idx == 0) m[0] = v & 8'hC1;
      else if (idx == 1 || idx == 2 || idx == 8) m[idx] = v;
   endfunction

   // R10: outputs compared against the model on every clock
   always @(negedge clk) begin
      if (mon_en && rst_n) begin
         check("R10 cfg0", cfg0_o, m_read(0));
         check("R10 out_en", out_en_o, m[1]);
         check("R10 stop_sel", stop_sel_o, m[2]);
         check("R10 count", rd_count_o, m[8]);
      end
      if (watch_pull && sda_pull_o) saw_pull = 1'b1;
   end

   task automatic qwait(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start;
      sda_h = 1'b1; qwait(Q); scl = 1'b1; qwait(Q);
      sda_h = 1'b0; qwait(Q); scl = 1'b0; qwait(Q);
   endtask

   task automatic bus_stop;
      sda_h = 1'b0; qwait(Q); scl = 1'b1; qwait(Q);
      sda_h = 1'b1; qwait(2*Q);
   endtask

   task automatic put_bit(input logic b);
      sda_h = b; qwait(Q); scl = 1'b1; qwait(2*Q); scl = 1'b0; qwait(Q);
   endtask

   task automatic get_bit(output logic b);
      sda_h = 1'b1; qwait(Q); scl = 1'b1; qwait(Q);
      b = sda_line; qwait(Q); scl = 1'b0; qwait(Q);
   endtask

   task automatic put_byte(input logic [7:0] v, output logic acked);
      logic a;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(a);
      acked = ~a;
   endtask

   task automatic get_byte(input logic host_ack, output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      put_bit(~host_ack);
   endtask

   task automatic ctl(input logic [7:0] v, input logic exp_ack, input string rq);
      logic a;
      put_byte(v, a);
      check(rq, a, exp_ack);
   endtask

   task automatic data(input logic [7:0] v, input logic exp_ack, inout int idx,
                       input string rq);
      logic a;
      mon_en = 1'b0;
      put_byte(v, a);
      check(rq, a, exp_ack);
      if (a) begin
         m_write(idx, v);
         idx++;
      end
      mon_en = 1'b1;
   endtask

   task automatic wr_hdr(input logic [7:0] n, input logic [7:0] x, input string rq);
      bus_start;
      ctl(8'hDC, 1'b1, rq);
      ctl(n, 1'b1, rq);
      ctl(x, 1'b1, rq);
   endtask

   task automatic rd_expect(input logic host_ack, input logic [7:0] exp, input string rq);
      logic [7:0] v;
      get_byte(host_ack, v);
      check(rq, v, exp);
   endtask

   initial begin
      int idx;
      for (int i = 0; i < 9; i++) m[i] = 8'h00;
      m[0] = 8'h81; m[1] = 8'hFF; m[2] = 8'h00; m[8] = 8'd9;
      mlat = 2'b10;
      qwait(5);
      rst_n = 1'b1;
      qwait(3);
      mode_pins = 2'b01;
      qwait(3);
      // R6 / R7 reset state: bit7=1, bit3=pin1=1, bit2=1, bit1=pin0=0, bit0=1
      check("R6 cfg0 reset", cfg0_o, 8'h8D);
      check("R6 out_en reset", out_en_o, 8'hFF);
      check("R6 stop_sel reset", stop_sel_o, 8'h00);
      check("R6 count reset", rd_count_o, 8'd9);
      check("R11 released at reset", sda_pull_o, 1'b0);
      mon_en = 1'b1;

      // R2: block write N=1 X=2 with auto-increment
      wr_hdr(8'd1, 8'd2, "R2 header ack");
      idx = 1;
      data(8'hA5, 1'b1, idx, "R2 data0 ack");
      data(8'h3C, 1'b1, idx, "R2 data1 ack");
      bus_stop;
      check("R2 out_en", out_en_o, 8'hA5);
      check("R2 stop_sel", stop_sel_o, 8'h3C);

      // R7: only bits 7,6,0 of index 0 writable; mode pins held from reset
      wr_hdr(8'd0, 8'd1, "R7 header ack");
      idx = 0;
      data(8'hFF, 1'b1, idx, "R7 data ack");
      bus_stop;
      check("R7 cfg0 masked write", cfg0_o, 8'hCD);

      // R8: reserved index write acknowledged and ignored
      wr_hdr(8'd4, 8'd1, "R8 header ack");
      idx = 4;
      data(8'h77, 1'b1, idx, "R8 data ack");
      bus_stop;

      // R1: wrong address gets no ack and SDA stays released
      saw_pull = 1'b0; watch_pull = 1'b1;
      bus_start;
      ctl(8'hA0, 1'b0, "R1 foreign address nack");
      ctl(8'h01, 1'b0, "R1 no ack after mismatch");
      bus_stop;
      watch_pull = 1'b0;
      check("R1 sda never pulled", saw_pull, 1'b0);

      // R4: set count to 4, then read from index 0
      wr_hdr(8'd8, 8'd1, "R4 count write ack");
      idx = 8;
      data(8'h04, 1'b1, idx, "R4 count data ack");
      bus_stop;
      bus_start;
      ctl(8'hDC, 1'b1, "R4 write address ack");
      ctl(8'd0, 1'b1, "R4 index ack");
      bus_start;
      ctl(8'hDD, 1'b1, "R4 read address ack");
      rd_expect(1'b1, 8'h04, "R4 count byte first");
      rd_expect(1'b1, 8'hCD, "R4 reg0");
      rd_expect(1'b1, 8'hA5, "R4 reg1");
      rd_expect(1'b1, 8'h3C, "R4 reg2");
      rd_expect(1'b0, 8'h00, "R8 reg3 reads zero");
      // R5: after the host nack the line stays released
      saw_pull = 1'b0; watch_pull = 1'b1;
      put_bit(1'b1); put_bit(1'b1);
      watch_pull = 1'b0;
      check("R5 released after nack", saw_pull, 1'b0);
      bus_stop;

      // R8: reserved index 4 reads zero after write
      bus_start;
      ctl(8'hDC, 1'b1, "R8 write address ack");
      ctl(8'd4, 1'b1, "R8 index ack");
      bus_start;
      ctl(8'hDD, 1'b1, "R8 read address ack");
      rd_expect(1'b1, 8'h04, "R8 count");
      rd_expect(1'b0, 8'h00, "R8 reg4 ignored write");
      bus_stop;

      // R8: index beyond the bank
      wr_hdr(8'd20, 8'd1, "R8 high index header");
      idx = 20;
      data(8'h99, 1'b1, idx, "R8 high index data ack");
      bus_stop;
      bus_start;
      ctl(8'hDC, 1'b1, "R8 write address ack");
      ctl(8'd20, 1'b1, "R8 index ack");
      bus_start;
      ctl(8'hDD, 1'b1, "R8 read address ack");
      rd_expect(1'b1, 8'h04, "R8 count");
      rd_expect(1'b0, 8'h00, "R8 high index reads zero");
      bus_stop;

      // R3: byte beyond the count is refused
      wr_hdr(8'd2, 8'd1, "R3 header ack");
      idx = 2;
      data(8'h11, 1'b1, idx, "R3 first data ack");
      data(8'h22, 1'b0, idx, "R3 extra byte nack");
      bus_stop;
      check("R3 stop_sel kept", stop_sel_o, 8'h11);

      // R9: STOP in the middle of the second data byte
      wr_hdr(8'd1, 8'd2, "R9 header ack");
      idx = 1;
      data(8'h5A, 1'b1, idx, "R9 data ack");
      for (int i = 0; i < 4; i++) put_bit(1'b0);
      bus_stop;
      check("R9 first byte kept", out_en_o, 8'h5A);
      check("R9 partial byte dropped", stop_sel_o, 8'h11);

      // R9: repeated START after one data byte; read shows advanced pointer
      wr_hdr(8'd1, 8'd2, "R9 header ack");
      idx = 1;
      data(8'h66, 1'b1, idx, "R9 data ack");
      bus_start;
      ctl(8'hDD, 1'b1, "R9 read after restart ack");
      rd_expect(1'b1, 8'h04, "R9 count");
      rd_expect(1'b0, 8'h11, "R9 reg2 untouched");
      bus_stop;
      check("R9 out_en updated", out_en_o, 8'h66);

      qwait(10);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog run did not complete");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule